// File: doc/BRIEF.md
# Burst Transfer Master Sequencer

This block sits on the master side of an AHB-style system bus. A local requester gives it a start address, a direction and a burst code. The block then drives the bus address-phase outputs for every beat of that burst. These are the transfer-type code, the beat address, the direction, the burst code and the transfer size. Only 32-bit word transfers are made, so the size output is constant and each beat moves four bytes.

The block supports single transfers, incrementing bursts of 4, 8 and 16 beats, and wrapping bursts of 4, 8 and 16 beats. In a wrapping burst the low address bits count modulo the burst span and the upper bits stay fixed. It also supports an open-ended incrementing burst, which lasts as long as the requester holds its continue input high.

Several conditions can interrupt a burst:
- If the local data source is not ready for the next beat, the block shows a BUSY cycle that already carries the next address. It then resumes with SEQ once the source is ready.
- A slave can stretch the bus by pulling the ready input low. While it is low, every output holds.
- An ERROR response ends the burst. The block returns to IDLE and pulses an error flag back to the requester.

A new request can be taken in the same cycle in which the last beat of the previous burst completes, so bursts can run back to back.

Top module: `bseq_top`

## Requirements
- R1: After reset the transfer type is IDLE (code 0), the error flag is low, and `req_ready` is high while `hready` is high.
- R2: Transfer-type codes are IDLE=0, BUSY=1, NONSEQ=2 and SEQ=3. The first beat of any burst is NONSEQ. Later beats are SEQ. A SINGLE burst shows one NONSEQ beat and then IDLE.
- R3: An INCR4, INCR8 or INCR16 burst issues exactly 4, 8 or 16 beats. Beat i has address start + 4·i.
- R4: A WRAP4, WRAP8 or WRAP16 burst issues 4, 8 or 16 beats. With span S = beats·4, beat i has address (start & ~(S-1)) | ((start + 4·i) & (S-1)).
- R5: An open-ended INCR burst keeps issuing beats at +4 while `incr_more` is high when a beat completes. When `incr_more` is low at a beat completion, the burst ends and the next cycle is IDLE or a new NONSEQ.
- R6: When a beat completes, more beats remain and `src_ready` is low, the next cycle shows BUSY with the next beat's address. Each later cycle with `src_ready` high turns that BUSY into SEQ at the same address.
- R7: While `hready` is low, the outputs `htrans`, `haddr`, `hwrite` and `hburst` hold their values into the next cycle.
- R8: When `hready` and `hresp` (1 = ERROR) are both high, the next cycle shows IDLE and `err_o` is high for exactly that one cycle.
- R9: A request is accepted (`req_ready` high) in any cycle with `hready` high and no error where the bus is idle or the last beat is completing. An accepted request shows as NONSEQ at the request address in the next cycle.
- R10: Burst codes are SINGLE=0, INCR=1, WRAP4=2, INCR4=3, WRAP8=4, INCR8=5, WRAP16=6 and INCR16=7. During a burst, `hburst` and `hwrite` echo the request and `hsize` is 2 (word). `incr_more` has no effect on fixed-length bursts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Requester presents a new burst |
| req_addr | input | ADDR_W | Start byte address, word aligned |
| req_write | input | 1 | 1 = write burst |
| req_burst | input | 3 | Burst code (R10) |
| req_ready | output | 1 | Request taken at this clock edge |
| incr_more | input | 1 | Continue an open-ended INCR burst |
| src_ready | input | 1 | Local data source ready for the next beat |
| hready | input | 1 | Bus ready; low stretches the current phase |
| hresp | input | 1 | Slave response, 1 = ERROR |
| htrans | output | 2 | Transfer type code |
| haddr | output | ADDR_W | Beat address |
| hwrite | output | 1 | Direction of the burst |
| hburst | output | 3 | Burst code of the burst in progress |
| hsize | output | 3 | Transfer size, always word |
| err_o | output | 1 | One-cycle error report to the requester |

## Verification
Two pairs of events can fall in the same cycle:
- A bus stall and a source stall. The bench draws `hready` and `src_ready` independently each cycle, so a BUSY decision can coincide with a stretched phase. A correct design holds BUSY, or holds the pending beat, until `hready` returns.
- The completion of a burst's last beat and a fresh request. These are provoked both by directed chained bursts and by random ones.

In every case the outputs are judged against an address list computed from the burst formulas, and against a transfer-type sequence predicted cycle by cycle from the inputs the bench drove.

// File: rtl/bseq_pkg.sv
package bseq_pkg;

    localparam int BEAT_BYTES = 4;
    localparam int BEAT_LG    = $clog2(BEAT_BYTES);

    typedef enum logic [1:0] {
        TR_IDLE   = 2'd0,
        TR_BUSY   = 2'd1,
        TR_NONSEQ = 2'd2,
        TR_SEQ    = 2'd3
    } trans_e;

    typedef enum logic [2:0] {
        BU_SINGLE = 3'd0,
        BU_INCR   = 3'd1,
        BU_WRAP4  = 3'd2,
        BU_INCR4  = 3'd3,
        BU_WRAP8  = 3'd4,
        BU_INCR8  = 3'd5,
        BU_WRAP16 = 3'd6,
        BU_INCR16 = 3'd7
    } burst_e;

endpackage

// File: rtl/bseq_decode.sv
// Turns a burst code into a beat count and the wrap / open-ended flags.
module bseq_decode #(
    parameter int CNT_W = 5
) (
    input  logic [2:0]       burst,
    output logic [CNT_W-1:0] beats,
    output logic             is_wrap,
    output logic             is_open
);
    always_comb begin
        is_open = (burst == 3'd1);
        is_wrap = (burst[2:1] != 2'd0) && !burst[0];
        if (burst == 3'd0) begin
            beats = CNT_W'(1);
        end else if (burst == 3'd1) begin
            beats = '0;
        end else begin
            // pairs 2/3, 4/5, 6/7 give 4, 8, 16 beats
            beats = CNT_W'(1) << ({1'b0, burst[2:1]} + 3'd1);
        end
    end
endmodule

// File: rtl/bseq_addr_step.sv
// Address of the beat after the current one, incrementing or wrapping.
module bseq_addr_step
    import bseq_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 5
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  beats,
    input  logic              is_wrap,
    output logic [ADDR_W-1:0] next_addr
);
    logic [ADDR_W-1:0] span;
    logic [ADDR_W-1:0] mask;
    logic [ADDR_W-1:0] inc;

    always_comb begin
        span = ADDR_W'(beats) << BEAT_LG;
        mask = span - ADDR_W'(1);
        inc  = addr + ADDR_W'(BEAT_BYTES);
        if (is_wrap) begin
            next_addr = (addr & ~mask) | (inc & mask);
        end else begin
            next_addr = inc;
        end
    end
endmodule

// File: rtl/bseq_top.sv
module bseq_top
    import bseq_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic [2:0]        req_burst,
    output logic              req_ready,
    input  logic              incr_more,
    input  logic              src_ready,
    input  logic              hready,
    input  logic              hresp,
    output logic [1:0]        htrans,
    output logic [ADDR_W-1:0] haddr,
    output logic              hwrite,
    output logic [2:0]        hburst,
    output logic [2:0]        hsize,
    output logic              err_o
);
    typedef struct packed {
        trans_e            trans;
        logic [ADDR_W-1:0] addr;
        logic              write;
        logic [2:0]        burst;
        logic [CNT_W-1:0]  left;   // beats still to show after the current one
        logic              err;
    } st_t;

    st_t st_q, st_d;

    logic [CNT_W-1:0]  new_beats, cur_beats;
    logic              new_wrap, new_open, cur_wrap, cur_open;
    logic [ADDR_W-1:0] step_addr;
    logic              more_beats;
    logic              take;

    bseq_decode #(.CNT_W(CNT_W)) u_dec_req (
        .burst   (req_burst),
        .beats   (new_beats),
        .is_wrap (new_wrap),
        .is_open (new_open)
    );

    bseq_decode #(.CNT_W(CNT_W)) u_dec_cur (
        .burst   (st_q.burst),
        .beats   (cur_beats),
        .is_wrap (cur_wrap),
        .is_open (cur_open)
    );

    bseq_addr_step #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_step (
        .addr      (st_q.addr),
        .beats     (cur_beats),
        .is_wrap   (cur_wrap),
        .next_addr (step_addr)
    );

    assign more_beats = cur_open ? incr_more : (st_q.left != '0);

    always_comb begin
        st_d     = st_q;
        st_d.err = 1'b0;
        take     = 1'b0;
        if (hready) begin
            if (hresp) begin
                st_d.trans = TR_IDLE;
                st_d.err   = 1'b1;
            end else begin
                unique case (st_q.trans)
                    TR_NONSEQ, TR_SEQ: begin
                        if (more_beats) begin
                            st_d.addr  = step_addr;
                            st_d.trans = src_ready ? TR_SEQ : TR_BUSY;
                            if (!cur_open) begin
                                st_d.left = st_q.left - CNT_W'(1);
                            end
                        end else begin
                            take = 1'b1;
                        end
                    end
                    TR_BUSY: begin
                        if (cur_open && !incr_more) begin
                            take = 1'b1;
                        end else if (src_ready) begin
                            st_d.trans = TR_SEQ;
                        end
                    end
                    default: take = 1'b1;
                endcase
                if (take) begin
                    if (req_valid) begin
                        st_d.trans = TR_NONSEQ;
                        st_d.addr  = req_addr;
                        st_d.write = req_write;
                        st_d.burst = req_burst;
                        st_d.left  = new_open ? '0 : new_beats - CNT_W'(1);
                    end else begin
                        st_d.trans = TR_IDLE;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{trans: TR_IDLE, addr: '0, write: 1'b0,
                      burst: 3'd0, left: '0, err: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign req_ready = take;
    assign htrans    = st_q.trans;
    assign haddr     = st_q.addr;
    assign hwrite    = st_q.write;
    assign hburst    = st_q.burst;
    assign hsize     = 3'(BEAT_LG);
    assign err_o     = st_q.err;

endmodule

// File: rtl/bseq_chk.sv
module bseq_chk
    import bseq_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hready,
    input logic              hresp,
    input logic              src_ready,
    input logic [1:0]        htrans,
    input logic [ADDR_W-1:0] haddr,
    input logic              hwrite,
    input logic [2:0]        hburst,
    input logic              err_o
);
    logic [ADDR_W-1:0] first_addr;
    logic [ADDR_W-1:0] span_mask;
    logic              wrapping;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            first_addr <= '0;
        end else if (htrans == TR_NONSEQ) begin
            first_addr <= haddr;
        end
    end

    always_comb begin
        wrapping = 1'b1;
        unique case (hburst)
            BU_WRAP4:  span_mask = ADDR_W'(15);
            BU_WRAP8:  span_mask = ADDR_W'(31);
            BU_WRAP16: span_mask = ADDR_W'(63);
            default: begin
                span_mask = '0;
                wrapping  = 1'b0;
            end
        endcase
    end

    p_seq_after_beat_r2: assert property (@(posedge clk) disable iff (!rst_n)
        htrans == TR_SEQ |-> $past(htrans) != TR_IDLE);

    p_wrap_region_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (htrans == TR_SEQ || htrans == TR_BUSY) && wrapping && $past(htrans) != TR_IDLE
        |-> ((haddr ^ first_addr) & ~span_mask) == '0);

    p_busy_in_burst_r6: assert property (@(posedge clk) disable iff (!rst_n)
        htrans == TR_BUSY |-> $past(htrans) != TR_IDLE);

    p_no_seq_unready_r6: assert property (@(posedge clk) disable iff (!rst_n)
        hready && !hresp && !src_ready |=> htrans != TR_SEQ);

    p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !hready |=> $stable(htrans) && $stable(haddr) && $stable(hwrite) && $stable(hburst));

    p_error_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hready && hresp |=> htrans == TR_IDLE && err_o);

    p_error_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> !err_o);

endmodule

bind bseq_top bseq_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .hready    (hready),
    .hresp     (hresp),
    .src_ready (src_ready),
    .htrans    (htrans),
    .haddr     (haddr),
    .hwrite    (hwrite),
    .hburst    (hburst),
    .err_o     (err_o)
);

// File: tb/bseq_top_tb_top.sv
module bseq_top_tb_top;

    localparam logic [1:0] T_IDLE = 2'd0, T_BUSY = 2'd1, T_NS = 2'd2, T_SEQ = 2'd3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic [2:0]  req_burst = '0;
    logic        req_ready;
    logic        incr_more = 1'b0;
    logic        src_ready = 1'b1;
    logic        hready = 1'b1;
    logic        hresp = 1'b0;
    logic [1:0]  htrans;
    logic [31:0] haddr;
    logic        hwrite;
    logic [2:0]  hburst;
    logic [2:0]  hsize;
    logic        err_o;

    int checks = 0;
    int errors = 0;

    logic [31:0] nx_addr;
    logic [2:0]  nx_burst;
    bit          nx_wr;

    always #5 clk = ~clk;

    bseq_top dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_write(req_write), .req_burst(req_burst), .req_ready(req_ready),
        .incr_more(incr_more), .src_ready(src_ready), .hready(hready), .hresp(hresp),
        .htrans(htrans), .haddr(haddr), .hwrite(hwrite), .hburst(hburst),
        .hsize(hsize), .err_o(err_o)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int nbeats(input logic [2:0] bt, input int nincr);
        case (bt)
            3'd0: return 1;
            3'd1: return nincr;
            3'd2, 3'd3: return 4;
            3'd4, 3'd5: return 8;
            default: return 16;
        endcase
    endfunction

    function automatic logic [31:0] exp_addr(input logic [31:0] st, input logic [2:0] bt,
                                             input int i);
        logic [31:0] span;
        if (bt inside {3'd2, 3'd4, 3'd6}) begin
            span = 32'(nbeats(bt, 1) * 4);
            return (st & ~(span - 1)) | ((st + 32'(4 * i)) & (span - 1));
        end
        return st + 32'(4 * i);
    endfunction

    function automatic string btag(input logic [2:0] bt);
        if (bt == 3'd0) return "R2";
        if (bt == 3'd1) return "R5";
        if (bt inside {3'd2, 3'd4, 3'd6}) return "R4";
        return "R3";
    endfunction

    // One burst with a cycle-by-cycle prediction of the bus outputs.
    task automatic do_burst(input logic [31:0] st, input logic [2:0] bt, input bit wr,
                            input int nincr, input int stall_pct, input int err_at,
                            input bit chain, input bit started);
        int          n = nbeats(bt, nincr);
        logic [1:0]  e_trans = T_NS;
        int          e_beat = 0;
        bit          e_err = 1'b0;
        bit          finished = 1'b0;
        bit          chained = 1'b0;
        bit          last_stall = 1'b0;
        string       tag;
        logic [31:0] ea;
        if (!started) begin
            @(negedge clk);
            req_valid = 1'b1; req_addr = st; req_write = wr; req_burst = bt;
            hready = 1'b1; hresp = 1'b0;
            #1 chk(req_ready == 1'b1, "R9 accept", 32'(req_ready), 32'd1);
            @(negedge clk);
            req_valid = 1'b0;
        end
        while (1) begin
            tag = last_stall ? "R7" : (e_trans == T_BUSY ? "R6" : btag(bt));
            chk(htrans == e_trans, tag, 32'(htrans), 32'(e_trans));
            if (e_trans != T_IDLE) begin
                ea = chained ? nx_addr : exp_addr(st, bt, e_beat);
                chk(haddr == ea, tag, haddr, ea);
                chk(hburst == (chained ? nx_burst : bt), "R10 burst", 32'(hburst),
                    32'(chained ? nx_burst : bt));
                chk(hwrite == (chained ? nx_wr : wr), "R10 write", 32'(hwrite), 32'(wr));
                chk(hsize == 3'd2, "R10 size", 32'(hsize), 32'd2);
            end
            chk(err_o == e_err, "R8 err", 32'(err_o), 32'(e_err));
            if (finished) break;
            hready = ($urandom % 100) >= stall_pct;
            src_ready = ($urandom % 100) >= stall_pct;
            if (bt == 3'd1) incr_more = (e_trans == T_BUSY) ? 1'b1 : (e_beat + 1 < n);
            else incr_more = $urandom % 2;
            hresp = hready && (err_at == e_beat) && (e_trans inside {T_NS, T_SEQ});
            req_valid = 1'b0;
            last_stall = !hready;
            e_err = 1'b0;
            if (hready) begin
                if (hresp) begin
                    e_trans = T_IDLE; e_err = 1'b1; finished = 1'b1;
                end else if (e_trans == T_NS || e_trans == T_SEQ) begin
                    if (e_beat + 1 < n) begin
                        e_beat++;
                        e_trans = src_ready ? T_SEQ : T_BUSY;
                    end else begin
                        finished = 1'b1;
                        if (chain) begin
                            req_valid = 1'b1; req_addr = nx_addr;
                            req_burst = nx_burst; req_write = nx_wr;
                            #1 chk(req_ready == 1'b1, "R9 chain", 32'(req_ready), 32'd1);
                            e_trans = T_NS; chained = 1'b1;
                        end else begin
                            e_trans = T_IDLE;
                        end
                    end
                end else if (e_trans == T_BUSY && src_ready) begin
                    e_trans = T_SEQ;
                end
            end
            @(negedge clk);
            req_valid = 1'b0;
        end
        hready = 1'b1; hresp = 1'b0; src_ready = 1'b1;
    endtask

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(htrans == T_IDLE, "R1 trans", 32'(htrans), 0);
        chk(err_o == 1'b0, "R1 err", 32'(err_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(htrans == T_IDLE, "R1 trans after release", 32'(htrans), 0);
        chk(req_ready == 1'b1, "R1 ready", 32'(req_ready), 1);

        do_burst(32'h100, 3'd0, 1'b1, 1, 0, -1, 1'b0, 1'b0);   // R2 single
        do_burst(32'h010, 3'd3, 1'b0, 1, 0, -1, 1'b0, 1'b0);   // R3 INCR4
        do_burst(32'h038, 3'd2, 1'b1, 1, 0, -1, 1'b0, 1'b0);   // R4 WRAP4 fold
        do_burst(32'h07C, 3'd4, 1'b0, 1, 30, -1, 1'b0, 1'b0);  // R4 WRAP8 last word
        do_burst(32'h1F4, 3'd6, 1'b1, 1, 40, -1, 1'b0, 1'b0);  // R4 WRAP16
        do_burst(32'h200, 3'd1, 1'b0, 5, 40, -1, 1'b0, 1'b0);  // R5 open, 5 beats
        do_burst(32'h300, 3'd1, 1'b1, 1, 0, -1, 1'b0, 1'b0);   // R5 open, 1 beat
        do_burst(32'h400, 3'd7, 1'b0, 1, 60, -1, 1'b0, 1'b0);  // R6 R7 heavy stalls
        do_burst(32'h500, 3'd5, 1'b1, 1, 20, 2, 1'b0, 1'b0);   // R8 error at beat 2
        nx_addr = 32'h600; nx_burst = 3'd0; nx_wr = 1'b1;
        do_burst(32'h580, 3'd3, 1'b0, 1, 0, -1, 1'b1, 1'b0);   // R9 chained
        do_burst(32'h600, 3'd0, 1'b1, 1, 0, -1, 1'b0, 1'b1);

        for (int k = 0; k < 60; k++) begin
            logic [2:0]  bt = 3'($urandom % 8);
            logic [31:0] st = $urandom & 32'h0000_FFFC;
            int          ni = 1 + $urandom % 6;
            int          sp = $urandom % 50;
            int          ea = (($urandom % 8) == 0) ? int'($urandom % nbeats(bt, ni)) : -1;
            do_burst(st, bt, 1'($urandom % 2), ni, sp, ea, 1'b0, 1'b0);
        end

        repeat (2) @(negedge clk);
        chk(htrans == T_IDLE, "R1 idle at end", 32'(htrans), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R1 act=running exp=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule